// File: doc/BRIEF.md
# Output Compare Unit

This block watches a timer count supplied from outside and compares it, on every clock, with a primary and a secondary compare register. From those matches it drives a single output pin and a one-cycle interrupt pulse. It has a three-bit mode register. The available behaviours are: force the pin high on a match, force it low on a match, toggle it on a match, a one-shot pulse between two matches, a repeating pulse between two matches, and a pulse-width modulator that takes its duty value from the secondary register. The timer is expected to advance by one count per clock. It also supplies a period-match strobe in the cycle that holds its last count, and the count wraps to zero after that cycle.

A controlling state machine decides how the matches act on the pin. The states are: IDLE (off or reserved mode), SINGLE (the three single-compare modes), ARM (a dual mode waiting for the primary match), HIGH (a dual mode waiting for the secondary match), DONE (the one-shot pulse has finished) and PWM. A mode write moves the machine to the entry state of the new mode (IDLE, SINGLE, ARM or PWM) and does not change the pin level. The other transitions are ARM to HIGH on a primary match, and HIGH to DONE (one-shot) or back to ARM (repeating) on a secondary match. The pin is registered, so each match becomes visible in the cycle after the timer showed the matching count.

Top module: `ocmp_unit`

## Requirements
- R1: After reset, pin_out and irq_pulse are 0.
- R2: In mode 1, a cycle with tmr_cnt equal to the primary value makes pin_out 1 from the next cycle on, with irq_pulse 1 for exactly that next cycle.
- R3: In mode 2, a primary match makes pin_out 0 from the next cycle on, with a one-cycle irq_pulse. If the pin was high when mode 2 was written, it stays high in every cycle until that match, without a single low cycle.
- R4: In mode 3, every primary match inverts pin_out in the next cycle and pulses irq_pulse.
- R5: In mode 0 and in the reserved mode 7, pin_out keeps its value and irq_pulse stays 0 whatever the timer does.
- R6: In modes 4 and 5, pin_out rises after a primary match, falls after the next secondary match, and irq_pulse pulses once on that secondary match.
- R7: In modes 4 and 5, a secondary value exactly one count after the primary value gives a pin pulse of exactly one cycle, and the falling edge is never skipped.
- R8: In mode 4, after the pulse ends, further matches have no effect on pin_out or irq_pulse until the mode is written again.
- R9: In mode 5, the pulse repeats in every timer period.
- R10: In mode 6, the secondary value is taken as the duty value at each period-match cycle. From the next cycle, pin_out is high for exactly that many timer counts (0 to duty-1), and it is low for the whole period when the duty is 0. A duty above the last count keeps the pin high.
- R11: In mode 6, changing the duty from 0 to 1 during a period gives a single one-count high pulse at the start of the next period, with the current period left low.
- R12: A register write takes effect from the cycle after the write strobe, and a mode write never changes pin_out by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_cnt | input | TW | Current timer count |
| tmr_period_hit | input | 1 | High in the cycle holding the timer's last count |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | New mode: 0 off, 1 set, 2 clear, 3 toggle, 4 one-shot, 5 repeating, 6 PWM, 7 reserved |
| pri_we | input | 1 | Primary compare write strobe |
| pri_wdata | input | TW | New primary compare value |
| sec_we | input | 1 | Secondary compare / duty write strobe |
| sec_wdata | input | TW | New secondary compare or duty value |
| pin_out | output | 1 | Registered compare output |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the unit with a 4-bit timer and counts from 0 to 9. With that size it can sweep every primary value in the single modes and every ordered pair of distinct primary and secondary values in both dual modes, including the adjacent pairs and the pairs that wrap around the period. It also covers every duty value the 4-bit register can hold, from 0 up to values past the period. While the unit is being configured, the bench holds the timer at count 15, which lies outside the counting range, so no match can happen during a register write.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    typedef enum logic [2:0] {
        MD_OFF = 3'd0,
        MD_SET = 3'd1,
        MD_CLR = 3'd2,
        MD_TGL = 3'd3,
        MD_ONE = 3'd4,
        MD_RPT = 3'd5,
        MD_PWM = 3'd6,
        MD_RSV = 3'd7
    } ocmp_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SINGLE,
        ST_ARM,
        ST_HIGH,
        ST_DONE,
        ST_PWM
    } ocmp_state_e;

    // Entry state taken by the controller when a mode is written
    function automatic ocmp_state_e entry_state(ocmp_mode_e m);
        ocmp_state_e s;
        unique case (m)
            MD_SET, MD_CLR, MD_TGL: s = ST_SINGLE;
            MD_ONE, MD_RPT:         s = ST_ARM;
            MD_PWM:                 s = ST_PWM;
            default:                s = ST_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
    import ocmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [2:0]        mode_wdata,
    input  logic              pri_we,
    input  logic [TW-1:0]     pri_wdata,
    input  logic              sec_we,
    input  logic [TW-1:0]     sec_wdata,
    output ocmp_mode_e        mode_q,
    output logic [TW-1:0]     pri_q,
    output logic [TW-1:0]     sec_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_OFF;
            pri_q  <= '0;
            sec_q  <= '0;
        end else begin
            if (mode_we) mode_q <= ocmp_mode_e'(mode_wdata);
            if (pri_we)  pri_q  <= pri_wdata;
            if (sec_we)  sec_q  <= sec_wdata;
        end
    end

endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
    parameter int TW = 16
) (
    input  logic [TW-1:0] tmr_cnt,
    input  logic [TW-1:0] pri_q,
    input  logic [TW-1:0] sec_q,
    input  logic [TW-1:0] duty_q,
    output logic          hit_pri,
    output logic          hit_sec,
    output logic          hit_duty
);

    localparam int NCMP = 3;

    logic [TW-1:0]   ref_v [NCMP];
    logic [NCMP-1:0] eq;

    // The duty edge is compared one count early so that the registered
    // pin is high for exactly duty counts.
    assign ref_v[0] = pri_q;
    assign ref_v[1] = sec_q;
    assign ref_v[2] = duty_q - TW'(1);

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        assign eq[g] = (tmr_cnt == ref_v[g]);
    end

    assign hit_pri  = eq[0];
    assign hit_sec  = eq[1];
    assign hit_duty = eq[2] && (duty_q != '0);

endmodule

// File: rtl/ocmp_fsm.sv
module ocmp_fsm
    import ocmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [2:0]        mode_wdata,
    input  ocmp_mode_e        mode_q,
    input  logic              tmr_period_hit,
    input  logic              hit_pri,
    input  logic              hit_sec,
    input  logic              hit_duty,
    input  logic [TW-1:0]     sec_q,
    output logic              pin_q,
    output logic              irq_q,
    output logic [TW-1:0]     duty_q,
    output ocmp_state_e       state_q
);

    ocmp_state_e   state_nx;
    logic          pin_nx;
    logic          irq_nx;
    logic [TW-1:0] duty_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        if (mode_we) begin
            state_nx = entry_state(ocmp_mode_e'(mode_wdata));
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SINGLE, ST_DONE, ST_PWM: state_nx = state_q;
                ST_ARM:  if (hit_pri) state_nx = ST_HIGH;
                ST_HIGH: if (hit_sec) state_nx = (mode_q == MD_RPT) ? ST_ARM : ST_DONE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Output decisions, taken from the current state
    always_comb begin
        pin_nx  = pin_q;
        irq_nx  = 1'b0;
        duty_nx = duty_q;
        unique case (state_q)
            ST_SINGLE: begin
                if (hit_pri) begin
                    irq_nx = 1'b1;
                    unique case (mode_q)
                        MD_SET:  pin_nx = 1'b1;
                        MD_CLR:  pin_nx = 1'b0;
                        MD_TGL:  pin_nx = ~pin_q;
                        default: pin_nx = pin_q;
                    endcase
                end
            end
            ST_ARM: begin
                if (hit_pri) pin_nx = 1'b1;
            end
            ST_HIGH: begin
                if (hit_sec) begin
                    pin_nx = 1'b0;
                    irq_nx = 1'b1;
                end
            end
            ST_PWM: begin
                if (tmr_period_hit) begin
                    duty_nx = sec_q;
                    pin_nx  = (sec_q != '0);
                end else if (hit_duty) begin
                    pin_nx  = 1'b0;
                end
            end
            default: begin
                pin_nx = pin_q;
            end
        endcase
        if (mode_we) duty_nx = '0;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q  <= 1'b0;
            irq_q  <= 1'b0;
            duty_q <= '0;
        end else begin
            pin_q  <= pin_nx;
            irq_q  <= irq_nx;
            duty_q <= duty_nx;
        end
    end

endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
    import ocmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tmr_cnt,
    input  logic          tmr_period_hit,
    input  logic          mode_we,
    input  logic [2:0]    mode_wdata,
    input  logic          pri_we,
    input  logic [TW-1:0] pri_wdata,
    input  logic          sec_we,
    input  logic [TW-1:0] sec_wdata,
    output logic          pin_out,
    output logic          irq_pulse
);

    ocmp_mode_e    mode_q;
    ocmp_state_e   fsm_state;
    logic [TW-1:0] pri_q;
    logic [TW-1:0] sec_q;
    logic [TW-1:0] duty_q;
    logic          hit_pri;
    logic          hit_sec;
    logic          hit_duty;

    ocmp_regs #(.TW(TW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .pri_we     (pri_we),
        .pri_wdata  (pri_wdata),
        .sec_we     (sec_we),
        .sec_wdata  (sec_wdata),
        .mode_q     (mode_q),
        .pri_q      (pri_q),
        .sec_q      (sec_q)
    );

    ocmp_match #(.TW(TW)) u_match (
        .tmr_cnt  (tmr_cnt),
        .pri_q    (pri_q),
        .sec_q    (sec_q),
        .duty_q   (duty_q),
        .hit_pri  (hit_pri),
        .hit_sec  (hit_sec),
        .hit_duty (hit_duty)
    );

    ocmp_fsm #(.TW(TW)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_we        (mode_we),
        .mode_wdata     (mode_wdata),
        .mode_q         (mode_q),
        .tmr_period_hit (tmr_period_hit),
        .hit_pri        (hit_pri),
        .hit_sec        (hit_sec),
        .hit_duty       (hit_duty),
        .sec_q          (sec_q),
        .pin_q          (pin_out),
        .irq_q          (irq_pulse),
        .duty_q         (duty_q),
        .state_q        (fsm_state)
    );

endmodule

// File: rtl/ocmp_unit_chk.sv
module ocmp_unit_chk
    import ocmp_pkg::*;
#(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input ocmp_mode_e    mode_q,
    input ocmp_state_e   fsm_state,
    input logic [TW-1:0] tmr_cnt,
    input logic [TW-1:0] pri_q,
    input logic [TW-1:0] sec_q,
    input logic          tmr_period_hit,
    input logic          mode_we,
    input logic          pin_out,
    input logic          irq_pulse
);

    // R2
    set_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_SET && tmr_cnt == pri_q) |=> (pin_out && irq_pulse));

    // R3
    clr_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_CLR) |=> !$rose(pin_out));

    // R4
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_TGL && tmr_cnt == pri_q) |=> (pin_out != $past(pin_out)));

    // R5
    off_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_OFF || mode_q == MD_RSV) |=> ($stable(pin_out) && !irq_pulse));

    // R7
    dual_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HIGH && tmr_cnt == sec_q) |=> (!pin_out && irq_pulse));

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DONE) |=> ($stable(pin_out) && !irq_pulse));

    // R10
    pwm_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_PWM && tmr_period_hit && !mode_we)
        |=> (pin_out == ($past(sec_q) != '0)));

endmodule

bind ocmp_unit ocmp_unit_chk #(.TW(TW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_q         (mode_q),
    .fsm_state      (fsm_state),
    .tmr_cnt        (tmr_cnt),
    .pri_q          (pri_q),
    .sec_q          (sec_q),
    .tmr_period_hit (tmr_period_hit),
    .mode_we        (mode_we),
    .pin_out        (pin_out),
    .irq_pulse      (irq_pulse)
);

// File: tb/ocmp_unit_test.sv
module ocmp_unit_test;
    import ocmp_pkg::*;

    localparam int TW    = 4;
    localparam int PER   = 9;
    localparam int LEN   = PER + 1;
    localparam int PARK  = 15;
    localparam int CLK_P = 10;
    localparam int WD    = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] tmr_cnt = TW'(PARK);
    logic          tmr_period_hit = 1'b0;
    logic          mode_we = 1'b0;
    logic [2:0]    mode_wdata = 3'd0;
    logic          pri_we = 1'b0;
    logic [TW-1:0] pri_wdata = '0;
    logic          sec_we = 1'b0;
    logic [TW-1:0] sec_wdata = '0;
    logic          pin_out;
    logic          irq_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int last_cnt;
    logic last_pin, last_irq;

    ocmp_unit #(.TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .tmr_period_hit(tmr_period_hit),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .pri_we(pri_we), .pri_wdata(pri_wdata),
        .sec_we(sec_we), .sec_wdata(sec_wdata), .pin_out(pin_out), .irq_pulse(irq_pulse)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic park();
        tmr_cnt = TW'(PARK);
        tmr_period_hit = 1'b0;
    endtask

    task automatic start();
        tmr_cnt = TW'(PER);
        tmr_period_hit = 1'b1;
    endtask

    // One clock: remember the count the design sees, then sample its result
    task automatic step();
        last_cnt = int'(tmr_cnt);
        tick();
        last_pin = pin_out;
        last_irq = irq_pulse;
        tmr_cnt = (int'(tmr_cnt) == PER) ? '0 : tmr_cnt + TW'(1);
        tmr_period_hit = (int'(tmr_cnt) == PER);
    endtask

    task automatic wr_mode(int m);
        mode_we = 1'b1; mode_wdata = 3'(m);
        tick();
        mode_we = 1'b0;
    endtask

    task automatic wr_pri(int v);
        pri_we = 1'b1; pri_wdata = TW'(v);
        tick();
        pri_we = 1'b0;
    endtask

    task automatic wr_sec(int v);
        sec_we = 1'b1; sec_wdata = TW'(v);
        tick();
        sec_we = 1'b0;
    endtask

    task automatic force_pin(logic lvl);
        wr_mode(MD_OFF);
        wr_pri(PER);
        wr_mode(lvl ? MD_SET : MD_CLR);
        start();
        step();
        park();
        wr_mode(MD_OFF);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic exp, hold;
        int j1, j2, d;

        // R1 reset state
        repeat (3) tick();
        chk("R1 pin in reset", pin_out, 1'b0);
        chk("R1 irq in reset", irq_pulse, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1 pin after reset", pin_out, 1'b0);
        chk("R1 irq after reset", irq_pulse, 1'b0);

        // Single-compare modes, every primary value
        for (int p = 0; p <= PER; p++) begin
            force_pin(1'b0);
            wr_pri(p);
            wr_mode(MD_SET);
            chk("R12 set mode write keeps pin", pin_out, 1'b0);
            start();
            exp = 1'b0;
            for (int j = 0; j <= LEN; j++) begin
                step();
                if (last_cnt == p) exp = 1'b1;
                chk($sformatf("R2 pin p=%0d j=%0d", p, j), last_pin, exp);
                chk($sformatf("R2 irq p=%0d j=%0d", p, j), last_irq, last_cnt == p);
            end
            park();
            wr_mode(MD_CLR);
            chk("R12 clear mode write keeps pin high", pin_out, 1'b1);
            start();
            exp = 1'b1;
            for (int j = 0; j <= LEN; j++) begin
                step();
                if (last_cnt == p) exp = 1'b0;
                chk($sformatf("R3 pin p=%0d j=%0d", p, j), last_pin, exp);
                chk($sformatf("R3 irq p=%0d j=%0d", p, j), last_irq, last_cnt == p);
            end
            park();
            wr_mode(MD_TGL);
            start();
            exp = 1'b0;
            for (int j = 0; j < 2*LEN + 1; j++) begin
                step();
                if (last_cnt == p) exp = ~exp;
                chk($sformatf("R4 pin p=%0d j=%0d", p, j), last_pin, exp);
                chk($sformatf("R4 irq p=%0d j=%0d", p, j), last_irq, last_cnt == p);
            end
            park();
            wr_mode((p % 2 == 0) ? MD_OFF : MD_RSV);
            hold = pin_out;
            start();
            for (int j = 0; j < LEN; j++) begin
                step();
                chk($sformatf("R5 pin p=%0d j=%0d", p, j), last_pin, hold);
                chk($sformatf("R5 irq p=%0d j=%0d", p, j), last_irq, 1'b0);
            end
            park();
        end

        // Dual-compare modes, every ordered pair of distinct values
        for (int md = MD_ONE; md <= MD_RPT; md++) begin
            for (int p = 0; p <= PER; p++) begin
                for (int s = 0; s <= PER; s++) begin
                    if (s != p) begin
                        force_pin(1'b0);
                        wr_pri(p);
                        wr_sec(s);
                        wr_mode(md);
                        start();
                        j1 = (p == PER) ? 0 : p + 1;
                        d  = (s - p + LEN) % LEN;
                        j2 = j1 + d;
                        for (int j = 0; j < 3*LEN; j++) begin
                            step();
                            if (md == MD_ONE) begin
                                exp  = (j >= j1) && (j < j2);
                                hold = (j == j2);
                            end else begin
                                exp  = (j >= j1) && (((j - j1) % LEN) < d);
                                hold = (j >= j2) && (((j - j2) % LEN) == 0);
                            end
                            if (d == 1)
                                chk($sformatf("R7 pin p=%0d s=%0d j=%0d", p, s, j), last_pin, exp);
                            else if (md == MD_ONE)
                                chk($sformatf("R8 pin p=%0d s=%0d j=%0d", p, s, j), last_pin, exp);
                            else
                                chk($sformatf("R9 pin p=%0d s=%0d j=%0d", p, s, j), last_pin, exp);
                            chk($sformatf("R6 irq mode=%0d p=%0d s=%0d j=%0d", md, p, s, j), last_irq, hold);
                        end
                        park();
                    end
                end
            end
        end

        // PWM, every duty value the register can hold
        for (int dv = 0; dv < (1 << TW); dv++) begin
            wr_sec(dv);
            wr_mode(MD_PWM);
            start();
            for (int j = 0; j < 2*LEN; j++) begin
                step();
                exp = (last_cnt == PER) ? (dv != 0) : (last_cnt < dv - 1);
                chk($sformatf("R10 pin duty=%0d j=%0d", dv, j), last_pin, exp);
                chk($sformatf("R10 irq duty=%0d j=%0d", dv, j), last_irq, 1'b0);
            end
            park();
        end

        // R11 duty 0 to 1 written in the middle of a period
        wr_sec(0);
        wr_mode(MD_PWM);
        start();
        for (int j = 0; j < 3*LEN; j++) begin
            if (j == 4) begin
                sec_we = 1'b1;
                sec_wdata = TW'(1);
            end
            step();
            sec_we = 1'b0;
            exp = (j >= LEN) && ((j % LEN) == 0);
            chk($sformatf("R11 pin j=%0d", j), last_pin, exp);
        end
        park();

        finish_run();
    end

endmodule